// File: doc/BRIEF.md
# CPU Clock Source Switch Controller

This block chooses the clock that drives the CPU from three free-running sources: an internal high-speed oscillator, an external high-speed system clock and a slow subsystem clock. Software sets two small control registers through a plain write/read port. The first register picks the main source, a power-of-two divider and whether the subsystem clock should drive the CPU. The second register sets the subsystem pin mode. A third address reads back status: which source really drives the CPU, and a sticky error flag.

Switching is glitch free. Each source has its own gating branch. A branch turns on only after every other branch has reported itself off. The request is resynchronised over two edges of the branch's own clock. The gate opens and closes on that clock's falling edge. The status bits follow the branch handshake, not the register write.

The controller checks every write against a set of guard rules. It ignores any write that would select a prohibited divider, select a stopped subsystem clock, alter the subsystem pin mode while that clock runs, or stop the subsystem clock while the CPU may still use it. Such a write sets the sticky error flag. A low-power stop request turns off the high-speed oscillator enables and leaves the subsystem clock running.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset both control registers read 0, the error flag is 0, the pin mode is 0 (general port), and once settled the CPU clock is the internal oscillator undivided with status cls=0, mcs=0.
- R2: Register 0 holds div in bits 2:0, css in bit 3 and main_sys in bit 4. It reads back zero-extended. With css=0, div codes 0 to 4 give a CPU clock equal to the main source (main_sys=0: internal oscillator, 1: system clock) divided by 2^div.
- R3: With css=1 and div=0 the CPU clock is the subsystem clock divided by 2.
- R4: A register-0 write is ignored and sets the sticky error flag (status bit 2) when css=1 with div not 0, css=0 with div above 4, or css=1 while the subsystem clock is off. The flag stays set until reset.
- R5: Register 1 holds sub_on in bit 0, ext_in in bit 1 and xt_start in bit 2. The pin mode output is 0 when sub_on=0, 1 (crystal, with sub_osc_en=1) when sub_on=1 and ext_in=0, and 2 (external input, sub_osc_en=0) when sub_on=1, ext_in=1, xt_start=0. A write with all three bits set is ignored and sets the error flag.
- R6: While sub_on=1, a register-1 write that changes ext_in or xt_start is ignored and sets the error flag.
- R7: A write clearing sub_on is accepted only when css=0 and the subsystem clock no longer drives the CPU. Otherwise it is ignored and sets the error flag.
- R8: While stop_req is high, osc_en and sys_en are 0, and sub_osc_en, the pin mode and a CPU clock taken from the subsystem clock are unchanged.
- R9: At most one source drives the CPU clock at any time. Every high pulse on cpu_clk is a full high phase of its source (no runt pulse).
- R10: Status bit 1 (cls) and bit 0 (mcs) change only when the switch has finished: cls=1 when the subsystem clock drives the CPU, mcs=1 when the system clock does. Right after a select write they still show the old source.
- R11: sys_en is high while main_sys=1 or while the system clock still drives the CPU, unless stop_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Internal high-speed oscillator clock |
| sys_clk | input | 1 | High-speed system clock |
| sub_clk | input | 1 | Subsystem clock |
| stop_req | input | 1 | Low-power stop request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 select, 1 subsystem control, 2 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| cpu_clk | output | 1 | Gated CPU clock |
| osc_en | output | 1 | Internal oscillator enable |
| sys_en | output | 1 | System clock enable |
| sub_osc_en | output | 1 | Subsystem crystal oscillator enable |
| sub_pin_mode | output | 2 | Subsystem pin mode: 0 port, 1 crystal, 2 external input |

## Verification
The bench watches every high pulse of cpu_clk and flags any pulse shorter than a source's half period, so a mux that swaps sources without the handshake shows up as a runt pulse. It reads status one cycle after each select write: a design that updates cls or mcs from the register and not from the branch handshake reports the new source too early. Directed writes try to stop the subsystem clock while the CPU runs on it, and to change its pin mode while it runs. A missing guard would then stop the CPU clock or show a changed register value. Random writes from a fixed seed mix legal and illegal divider and select codes. After each one the bench compares register contents, the error flag, the status and the measured cpu_clk period with a model.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int NSRC         = 3;
  localparam int SRC_OSC      = 0;
  localparam int SRC_SYS      = 1;
  localparam int SRC_SUB      = 2;
  localparam int DIV_W        = 3;
  localparam int MAX_DIV_CODE = 4;
  localparam int SUB_DIV_CODE = 1;
  localparam int CNT_W        = MAX_DIV_CODE;
  localparam int SRC_IDX_W    = $clog2(NSRC);

  typedef enum logic [1:0] {
    PIN_PORT = 2'd0,
    PIN_XTAL = 2'd1,
    PIN_EXT  = 2'd2
  } pin_mode_e;

  typedef struct packed {
    logic             main_sys;
    logic             sub_cpu;
    logic [DIV_W-1:0] div;
  } clk_sel_t;

  typedef struct packed {
    logic xt_start;
    logic ext_in;
    logic sub_on;
  } sub_ctl_t;

  localparam int SEL_W = $bits(clk_sel_t);
  localparam int SUB_W = $bits(sub_ctl_t);

  function automatic logic sel_legal(clk_sel_t s, logic sub_running);
    if (s.sub_cpu) return (s.div == '0) && sub_running;
    return (int'(s.div) <= MAX_DIV_CODE);
  endfunction

  function automatic pin_mode_e pin_mode_of(sub_ctl_t c);
    if (!c.sub_on) return PIN_PORT;
    if (!c.ext_in) return PIN_XTAL;
    return PIN_EXT;
  endfunction
endpackage

// File: rtl/cks_rst_sync.sv
module cks_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cks_regs.sv
module cks_regs
  import cks_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sub_busy,
  output clk_sel_t          sel_q,
  output sub_ctl_t          sub_q,
  output logic              err_q
);
  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_SUB = 2'd1;

  clk_sel_t sel_d, sel_wr;
  sub_ctl_t sub_d, sub_wr;
  logic     err_d;
  logic     sel_ok, sub_ok, sub_frozen_ok, sub_stop_ok;
  logic     unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:SEL_W];

  always_comb begin
    sel_wr = clk_sel_t'(wdata[SEL_W-1:0]);
    sub_wr = sub_ctl_t'(wdata[SUB_W-1:0]);
    sel_ok = sel_legal(sel_wr, sub_q.sub_on);
    sub_frozen_ok = !sub_q.sub_on ||
                    ((sub_wr.ext_in == sub_q.ext_in) && (sub_wr.xt_start == sub_q.xt_start));
    sub_stop_ok   = !sub_q.sub_on || sub_wr.sub_on || (!sub_busy && !sel_q.sub_cpu);
    sub_ok = !(sub_wr.sub_on && sub_wr.ext_in && sub_wr.xt_start) && sub_frozen_ok && sub_stop_ok;
  end

  always_comb begin
    sel_d = sel_q;
    sub_d = sub_q;
    err_d = err_q;
    if (wr_en) begin
      unique case (addr)
        A_SEL: if (sel_ok) sel_d = sel_wr; else err_d = 1'b1;
        A_SUB: if (sub_ok) sub_d = sub_wr; else err_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      sub_q <= '0;
      err_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      sub_q <= sub_d;
      err_q <= err_d;
    end
  end

  AST_REJECT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEL && wdata[3] && wdata[2:0] != 3'd0) |=> ($stable(sel_q) && err_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R4
  AST_SUB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q.sub_on |=> (!sub_q.sub_on ||
      (sub_q.ext_in == $past(sub_q.ext_in) && sub_q.xt_start == $past(sub_q.xt_start)))); // R6
  AST_STOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q.sub_on && (sub_busy || sel_q.sub_cpu)) |=> sub_q.sub_on); // R7
endmodule

// File: rtl/cks_status.sv
module cks_status
  import cks_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      on_raw,
  input  logic [SRC_IDX_W-1:0] tgt,
  output logic [NSRC-1:0]      on_s,
  output logic [NSRC-1:0]      sel_q,
  output logic                 cls_q,
  output logic                 mcs_q
);
  logic [NSRC-1:0] on_m;
  logic [NSRC-1:0] sel_d;
  logic            done;
  logic            cls_d, mcs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_m <= '0;
      on_s <= '0;
    end else begin
      on_m <= on_raw;
      on_s <= on_m;
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      sel_d[i] = (int'(tgt) == i) && ((on_s & ~(NSRC'(1) << i)) == '0);
    end
    done  = (on_s != '0) && ((on_s & (on_s - NSRC'(1))) == '0);
    cls_d = done ? on_s[SRC_SUB] : cls_q;
    mcs_d = done ? on_s[SRC_SYS] : mcs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cls_q <= 1'b0;
      mcs_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      cls_q <= cls_d;
      mcs_q <= mcs_d;
    end
  end

  AST_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(on_s)); // R9
  AST_CLS_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cls_q) |-> $past(on_s == (NSRC'(1) << SRC_SUB))); // R10
  AST_MCS_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcs_q) |-> $past(on_s == (NSRC'(1) << SRC_SYS))); // R10
endmodule

// File: rtl/cks_branch.sv
module cks_branch
  import cks_pkg::*;
(
  input  logic             src_clk,
  input  logic             arst_n,
  input  logic             sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             on_o,
  output logic             clk_o
);
  logic             rst_n;
  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             tick;
  logic             on_q, gate_q, gate_d;

  cks_rst_sync #(.STAGES(2)) u_rst (
    .clk(src_clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(div_i));
    cnt_d  = cnt_q + CNT_W'(1);
    tick   = ((cnt_q & mask) == mask);
    gate_d = s2_q && tick;
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= sel_i;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      on_q   <= s2_q;
      gate_q <= gate_d;
    end
  end

  assign on_o  = on_q;
  assign clk_o = src_clk & gate_q;

  AST_GATE_NEEDS_SEL: assert property (@(negedge src_clk) disable iff (!rst_n)
    gate_q |-> $past(s2_q)); // R9
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import cks_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              osc_clk,
  input  logic              sys_clk,
  input  logic              sub_clk,
  input  logic              stop_req,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cpu_clk,
  output logic              osc_en,
  output logic              sys_en,
  output logic              sub_osc_en,
  output logic [1:0]        sub_pin_mode
);
  logic                 rst_n;
  clk_sel_t             sel_q;
  sub_ctl_t             sub_q;
  logic                 err_q, cls_q, mcs_q;
  logic [NSRC-1:0]      on_raw, on_s, br_sel, gclk, src_clks;
  logic [SRC_IDX_W-1:0] tgt;
  logic                 sub_busy;

  cks_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  assign sub_busy = cls_q | on_s[SRC_SUB] | br_sel[SRC_SUB];

  cks_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sub_busy(sub_busy), .sel_q(sel_q), .sub_q(sub_q), .err_q(err_q)
  );

  always_comb begin
    if (sel_q.sub_cpu)       tgt = SRC_IDX_W'(SRC_SUB);
    else if (sel_q.main_sys) tgt = SRC_IDX_W'(SRC_SYS);
    else                     tgt = SRC_IDX_W'(SRC_OSC);
  end

  cks_status u_status (
    .clk(clk), .rst_n(rst_n), .on_raw(on_raw), .tgt(tgt),
    .on_s(on_s), .sel_q(br_sel), .cls_q(cls_q), .mcs_q(mcs_q)
  );

  always_comb begin
    src_clks          = '0;
    src_clks[SRC_OSC] = osc_clk;
    src_clks[SRC_SYS] = sys_clk;
    src_clks[SRC_SUB] = sub_clk;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [DIV_W-1:0] div_g;
    if (g == SRC_SUB) begin : g_fixed
      assign div_g = DIV_W'(SUB_DIV_CODE);
    end else begin : g_prog
      assign div_g = sel_q.div;
    end
    cks_branch u_branch (
      .src_clk(src_clks[g]), .arst_n(arst_n), .sel_i(br_sel[g]),
      .div_i(div_g), .on_o(on_raw[g]), .clk_o(gclk[g])
    );
  end

  assign cpu_clk      = |gclk;
  assign osc_en       = !stop_req;
  assign sys_en       = !stop_req && (sel_q.main_sys || on_s[SRC_SYS] || br_sel[SRC_SYS]);
  assign sub_osc_en   = sub_q.sub_on && !sub_q.ext_in;
  assign sub_pin_mode = pin_mode_of(sub_q);

  always_comb begin
    unique case (addr)
      2'd0:    rdata = DATA_W'(sel_q);
      2'd1:    rdata = DATA_W'(sub_q);
      2'd2:    rdata = DATA_W'({err_q, cls_q, mcs_q});
      default: rdata = '0;
    endcase
  end

  AST_STOP_KEEPS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && $past(stop_req) && !wr_en && !$past(wr_en)) |-> $stable(sub_osc_en)); // R8
endmodule

// File: tb/cpu_clk_switch_bench.sv
`timescale 1ns/1ps
module cpu_clk_switch_bench;
  logic clk = 0, osc_clk = 0, sys_clk = 0, sub_clk = 0;
  logic arst_n, stop_req, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic cpu_clk, osc_en, sys_en, sub_osc_en;
  logic [1:0] sub_pin_mode;

  always #10 clk = ~clk;
  always #5  osc_clk = ~osc_clk;
  always #7  sys_clk = ~sys_clk;
  always #30 sub_clk = ~sub_clk;

  cpu_clk_switch u_cpu_clk_switch (
    .clk(clk), .arst_n(arst_n), .osc_clk(osc_clk), .sys_clk(sys_clk), .sub_clk(sub_clk),
    .stop_req(stop_req), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cpu_clk(cpu_clk), .osc_en(osc_en), .sys_en(sys_en), .sub_osc_en(sub_osc_en),
    .sub_pin_mode(sub_pin_mode)
  );

  int checks = 0, errors = 0, runts = 0;
  bit done = 0, watch_pulses = 0;
  realtime t_rise = 0;
  logic [4:0] m_sel;
  logic [2:0] m_sub;
  logic       m_err;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge cpu_clk) t_rise = $realtime;
  always @(negedge cpu_clk) begin
    if (watch_pulses) begin
      int w;
      w = int'(($realtime - t_rise) * 1000.0);
      if (w != 5000 && w != 7000 && w != 30000) runts++;
    end
  end

  function automatic int exp_period();
    if (m_sel[3]) return 120;
    return (m_sel[4] ? 14 : 10) * (1 << m_sel[2:0]);
  endfunction
  function automatic int exp_status();
    return {m_err, m_sel[3], m_sel[3] ? 1'b0 : m_sel[4]};
  endfunction
  function automatic int exp_pin();
    if (!m_sub[0]) return 0;
    return m_sub[1] ? 2 : 1;
  endfunction
  function automatic bit sel_accept(input logic [4:0] d);
    if (d[3]) return (d[2:0] == 0) && m_sub[0];
    return d[2:0] <= 4;
  endfunction
  function automatic bit sub_accept(input logic [2:0] d);
    if (d == 3'b111) return 0;
    if (!m_sub[0]) return 1;
    if (d[2:1] != m_sub[2:1]) return 0;
    if (!d[0] && m_sel[3]) return 0;
    return 1;
  endfunction

  task automatic do_reset();
    arst_n = 0; wr_en = 0; addr = 0; wdata = 0; stop_req = 0;
    repeat (4) @(negedge clk);
    arst_n = 1;
    m_sel = 0; m_sub = 0; m_err = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 2'd0) begin
      if (sel_accept(d[4:0])) m_sel = d[4:0]; else m_err = 1;
    end else if (a == 2'd1) begin
      if (sub_accept(d[2:0])) m_sub = d[2:0]; else m_err = 1;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #2; v = rdata;
  endtask

  task automatic settle(input string req);
    int v, n;
    n = 0;
    rd(2, v);
    while (v != exp_status() && n < 4000) begin
      @(negedge clk); rd(2, v); n++;
    end
    check(req, v, exp_status());
  endtask

  task automatic meas(input string req);
    realtime t0;
    repeat (4) @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    #1;
    check(req, int'($realtime - 1.0 - t0), exp_period());
  endtask

  task automatic check_regs(input string req);
    int v;
    @(negedge clk);
    rd(0, v); check(req, v, {3'b0, m_sel});
    rd(1, v); check(req, v, {5'b0, m_sub});
  endtask

  task automatic check_pins(input string req);
    check(req, sub_pin_mode, exp_pin());
    check(req, sub_osc_en, m_sub[0] && !m_sub[1]);
    check(req, osc_en, !stop_req);
    check(req, sys_en, m_sel[4] && !stop_req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd2718));
    do_reset();
    // R1 reset state
    check_regs("R1");
    settle("R1");
    check_pins("R1");
    watch_pulses = 1;
    meas("R1");
    // R2 divider and main source
    wr(0, 8'h03); settle("R2"); meas("R2");
    wr(0, 8'h12);
    rd(2, v); check("R10 mcs early", v, 3'b000);
    settle("R10"); meas("R2");
    wr(0, 8'h00);
    check("R11 sys_en held", sys_en, 1);
    settle("R2"); check("R11 sys_en off", sys_en, 0);
    // R4 select while subsystem off
    wr(0, 8'h08); check_regs("R4"); settle("R4");
    // R5 pin modes
    wr(1, 8'h07); check_regs("R5 prohibited");
    wr(1, 8'h01); check_regs("R5"); check_pins("R5");
    // R6 frozen mode
    wr(1, 8'h03); check_regs("R6");
    // R4 divider with css
    wr(0, 8'h09); check_regs("R4");
    // R3 / R10 switch to subsystem
    wr(0, 8'h08);
    rd(2, v); check("R10 cls early", v, 3'b100);
    settle("R3"); meas("R3");
    // R7 stop while in use
    wr(1, 8'h00); check_regs("R7"); check_pins("R7");
    // R8 stop request
    stop_req = 1; #2;
    check_pins("R8"); meas("R8");
    stop_req = 0;
    wr(0, 8'h00); settle("R7");
    wr(1, 8'h00); check_regs("R7 stop ok"); check_pins("R7");
    wr(1, 8'h03); check_pins("R5 ext"); check_regs("R5");
    // random phase
    do_reset();
    check_regs("R4 err cleared"); settle("R1");
    for (int it = 0; it < 60; it++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = ($urandom % 3 == 0) ? 2'd1 : 2'd0;
      d = $urandom;
      if (a == 2'd0) d[2:0] = 3'($urandom % 6);
      wr(a, d);
      check_regs(a == 0 ? "R2" : "R6");
      settle("R10");
      check_pins("R5");
      meas(m_sel[3] ? "R3" : "R2");
    end
    watch_pulses = 0;
    check("R9 runt pulses", runts, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule